// File: doc/BRIEF.md
# Keyed Multi-Line Reset Controller

This block holds a bank of individually controlled reset lines for the peripherals next to it. Software drives the lines through two registers on a simple register bus. One register carries a request bit for each line. The other is a permission mask that says which lines software may drive at all. A line goes active only when its request bit and its permission bit are both set. The output flops change one clock after the write that causes the change.

Every write must carry a fixed key value in its top byte. A write without the key is thrown away whole, so a stray store cannot pull a peripheral into reset. The expected order for one line is:

1. Set its permission bit.
2. Set its request bit.
3. Clear the request bit.
4. Clear the permission bit.

Reads return the stored bits. The key field and all bits above the last line read as zero.

Top module: `keyed_reset_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rst_out`, `rdata`, the request register and the permission register are all zero.
- R2: A write (`wr_en`=1) to address 0x18 with `wdata[31:24]`=0x88 loads `wdata[NUM_LINES-1:0]` into the request register.
- R3: A write whose `wdata[31:24]` differs from 0x88 changes neither register, whatever its address.
- R4: A write to address 0xFC with `wdata[31:24]`=0x88 loads `wdata[NUM_LINES-1:0]` into the permission register.
- R5: `rst_out[i]` equals (request bit i AND permission bit i) as held one cycle earlier. An accepted write at clock edge k shows on `rst_out` after edge k+1.
- R6: A line whose permission bit is clear stays low even when its request bit is set.
- R7: A read (`rd_en`=1) is answered on `rdata` after the next edge. Address 0x18 returns the request bits and 0xFC returns the permission bits, both in `rdata[NUM_LINES-1:0]`. Bits 31 down to NUM_LINES read zero, and any other address reads zero.
- R8: A keyed write to any address other than 0x18 or 0xFC changes neither register.
- R9: Clearing a request bit, or its permission bit, drops the line one cycle after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Register byte address |
| wdata | input | DATA_W (32) | Write data; key in the top byte |
| rdata | output | DATA_W (32) | Registered read data |
| rst_out | output | NUM_LINES (24) | Reset lines, active high |

## Verification
The checker watches several rules on every cycle:

- A write without the key leaves both registers untouched.
- Every line follows the AND of request and permission one cycle later.
- No line is high without its permission bit.
- Read data never carries bits above the last line.
- A keyed write to the request register lands exactly.

Other behaviour is shown only by the bench scenarios. These cover the full enable, assert, release and disable order on chosen lines, and the exact cycle a line moves. They also cover reads of unmapped addresses, keyed writes to unmapped addresses, and near-miss keys. A long stream of random keyed and unkeyed traffic is compared against a bench model.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int KEY_W          = 8;
  localparam logic [7:0] KEY_VALUE = 8'h88;
  localparam int CTRL_OFS       = 'h18;
  localparam int MASK_OFS       = 'hFC;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rstc_key_gate.sv
module rstc_key_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ld_ctrl,
  output logic              ld_mask
);
  import rstc_pkg::*;

  logic     key_ok;
  reg_sel_e sel;

  always_comb begin
    key_ok = (wdata[DATA_W-1 -: KEY_W] == KEY_VALUE);
    if (addr == ADDR_W'(CTRL_OFS))      sel = SEL_CTRL;
    else if (addr == ADDR_W'(MASK_OFS)) sel = SEL_MASK;
    else                                sel = SEL_NONE;
    ld_ctrl = wr_en && key_ok && (sel == SEL_CTRL);
    ld_mask = wr_en && key_ok && (sel == SEL_MASK);
  end
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs #(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_ctrl,
  input  logic                 ld_mask,
  input  logic [NUM_LINES-1:0] din,
  output logic [NUM_LINES-1:0] ctrl_q,
  output logic [NUM_LINES-1:0] mask_q
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[i] <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        if (ld_ctrl) ctrl_q[i] <= din[i];
        if (ld_mask) mask_q[i] <= din[i];
      end
    end
  end
endmodule

// File: rtl/rstc_out_stage.sv
module rstc_out_stage #(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] ctrl_q,
  input  logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] rst_out
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) rst_out[i] <= 1'b0;
      else     rst_out[i] <= ctrl_q[i] & mask_q[i];
    end
  end
endmodule

// File: rtl/rstc_read_port.sv
module rstc_read_port #(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] ctrl_q,
  input  logic [NUM_LINES-1:0] mask_q,
  output logic [DATA_W-1:0]    rdata
);
  import rstc_pkg::*;

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(CTRL_OFS))      rd_next[NUM_LINES-1:0] = ctrl_q;
    else if (addr == ADDR_W'(MASK_OFS)) rd_next[NUM_LINES-1:0] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/keyed_reset_ctrl.sv
module keyed_reset_ctrl #(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_LINES-1:0] rst_out
);
  localparam int FREE_BITS = DATA_W - rstc_pkg::KEY_W;

  logic                 ld_ctrl;
  logic                 ld_mask;
  logic [NUM_LINES-1:0] ctrl_q;
  logic [NUM_LINES-1:0] mask_q;

  if (NUM_LINES > FREE_BITS) begin : g_bad_cfg
    initial $error("NUM_LINES overlaps the key field");
  end

  rstc_key_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .ld_ctrl (ld_ctrl),
    .ld_mask (ld_mask)
  );

  rstc_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .ld_ctrl (ld_ctrl),
    .ld_mask (ld_mask),
    .din     (wdata[NUM_LINES-1:0]),
    .ctrl_q  (ctrl_q),
    .mask_q  (mask_q)
  );

  rstc_out_stage #(.NUM_LINES(NUM_LINES)) u_out (
    .clk     (clk),
    .rst     (rst),
    .ctrl_q  (ctrl_q),
    .mask_q  (mask_q),
    .rst_out (rst_out)
  );

  rstc_read_port #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .ctrl_q (ctrl_q),
    .mask_q (mask_q),
    .rdata  (rdata)
  );
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic [NUM_LINES-1:0] rst_out,
  input logic [NUM_LINES-1:0] ctrl_q,
  input logic [NUM_LINES-1:0] mask_q
);
  import rstc_pkg::*;

  localparam logic [DATA_W-1:0] LINE_MASK = DATA_W'((64'd1 << NUM_LINES) - 64'd1);

  logic bad_key;
  logic good_ctrl_wr;
  assign bad_key      = wr_en && (wdata[DATA_W-1 -: KEY_W] != KEY_VALUE);
  assign good_ctrl_wr = wr_en && (wdata[DATA_W-1 -: KEY_W] == KEY_VALUE)
                        && (addr == ADDR_W'(CTRL_OFS));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rst_out == '0 && rdata == '0));

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
    good_ctrl_wr |=> (ctrl_q == $past(wdata[NUM_LINES-1:0])));

  assert_bad_key_hold_R3: assert property (@(posedge clk) disable iff (rst)
    bad_key |=> ($stable(ctrl_q) && $stable(mask_q)));

  assert_line_follows_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rst_out == ($past(ctrl_q) & $past(mask_q))));

  assert_gated_low_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rst_out & ~$past(mask_q)) == '0));

  assert_read_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rdata & ~LINE_MASK) == '0));
endmodule

bind keyed_reset_ctrl rstc_checker #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .rst_out (rst_out),
  .ctrl_q  (ctrl_q),
  .mask_q  (mask_q)
);

// File: tb/tb_keyed_reset_ctrl.sv
`timescale 1ns/1ps
module tb_keyed_reset_ctrl;
  localparam int N  = 24;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_CTRL = 8'h18;
  localparam logic [AW-1:0] A_MASK = 8'hFC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  rst_out;

  int total = 0, bad = 0;
  logic [N-1:0] m_ctrl = '0, m_mask = '0;

  always #2.5 clk = ~clk;

  keyed_reset_ctrl #(.NUM_LINES(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_out(rst_out)
  );

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    if (a == A_CTRL)      v[N-1:0] = m_ctrl;
    else if (a == A_MASK) v[N-1:0] = m_mask;
    return v;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one write cycle; model updated as requirements state
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (d[DW-1 -: 8] == 8'h88) begin
      if (a == A_CTRL) m_ctrl = d[N-1:0];
      else if (a == A_MASK) m_mask = d[N-1:0];
    end
  endtask

  task automatic rd_check(string req, logic [AW-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp_read(a));
  endtask

  task automatic settle_check(string req);
    @(negedge clk);
    check(req, DW'(rst_out), DW'(m_ctrl & m_mask));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check("R1 rst_out in reset", DW'(rst_out), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rst_out after reset", DW'(rst_out), '0);
    rd_check("R1 ctrl read", A_CTRL);
    rd_check("R1 mask read", A_MASK);

    // sequence on line 5, line 6 requested without permission
    wr(A_MASK, 32'h8800_0020);
    rd_check("R4 mask stored", A_MASK);
    wr(A_CTRL, 32'h8800_0060);
    check("R5 no change yet", DW'(rst_out), '0);
    @(negedge clk);
    check("R5 line5 up after one clock", DW'(rst_out), 32'h20);
    check("R6 line6 held low", DW'(rst_out[6]), '0);
    rd_check("R2 ctrl stored", A_CTRL);

    // wrong keys
    wr(A_CTRL, 32'h8900_0000);
    wr(A_MASK, 32'h0800_0000);
    wr(A_CTRL, 32'h0000_0000);
    settle_check("R3 bad key ignored");
    check("R3 line5 still up", DW'(rst_out), 32'h20);
    rd_check("R3 ctrl unchanged", A_CTRL);

    // keyed write to unmapped address
    wr(8'h20, 32'h8800_0000);
    wr(8'h1C, 32'h88FF_FFFF);
    settle_check("R8 unmapped write ignored");
    rd_check("R8 mask unchanged", A_MASK);
    rd_check("R7 unmapped read zero", 8'h40);

    // release then disable
    wr(A_CTRL, 32'h8800_0040);
    @(negedge clk);
    check("R9 release drops line", DW'(rst_out), '0);
    wr(A_MASK, 32'h8800_0040);
    @(negedge clk);
    check("R9 line6 up once permitted", DW'(rst_out), 32'h40);
    wr(A_MASK, 32'h8800_0000);
    @(negedge clk);
    check("R9 clearing permission drops line", DW'(rst_out), '0);

    // full width, upper bits read zero
    wr(A_CTRL, 32'h88FF_FFFF);
    wr(A_MASK, 32'h88FF_FFFF);
    rd_check("R7 ctrl read upper zero", A_CTRL);
    check("R7 literal value", rdata, 32'h00FF_FFFF);
    settle_check("R5 all lines");

    // random traffic
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int pick = $urandom_range(0, 9);
      a = (pick < 4) ? A_CTRL : (pick < 8) ? A_MASK : AW'($urandom);
      d = $urandom;
      if ($urandom_range(0, 3) != 0) d[DW-1 -: 8] = 8'h88;
      if ($urandom_range(0, 1) == 1) begin
        wr(a, d);
        settle_check("R5 random line state");
      end else begin
        rd_check("R7 random read", a);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule